// File: doc/BRIEF.md
# Hash Unit Control Sequencer

This block is the control and buffering front end of a message digest unit that can run SHA-1, MD5 or MD4. Software reaches it through a simple word-wide register bus. On that bus it sets a mode/control word, fills a double-buffered 512-bit message block one 32-bit word at a time, and reads back the digest. The round engine itself sits outside the block. The sequencer hands the engine one block per start pulse, paces its rounds, and listens for its done pulse.

Keyed hashing (HMAC) is handled in hardware. While an inner or outer pad flag is set, each written word is XORed with the pad pattern as it is stored. When an outer-pad block starts, the current digest is copied into the other buffer, together with the closing pad bits and a length field. That second block then follows on its own. A block that is completely written while the engine is busy is also queued and runs after the current one, with no further command.

A done pulse sets a sticky status bit, and a global enable gates that bit onto the interrupt line. A step mode lets software advance the engine one round at a time. A soft reset command aborts everything.

Top module: `hash_ctrl_seq`

## Requirements
- R1: The control word sits at bus address 0. Bit k of the bus word carries control bit 31-k. The stored fields are: auto-start bit 20 (bus bit 11), outer pad bit 21 (bus 10), inner pad bit 22 (bus 9), MD5 bit 24 (bus 7), MD4 bit 25 (bus 6), interrupt enable bit 27 (bus 4), byte swap bit 29 (bus 2) and step bit 30 (bus 1). All of them read back as written. The reset command bit 26 (bus 5) and start command bit 28 (bus 3) always read 0. Reserved bits 0–19, 23 and 31 ignore writes and read 0.
- R2: `engAlgo` is 1 when MD5 is set, 2 when MD4 alone is set, and 0 (SHA-1) when neither is set. MD5 wins when both are set.
- R3: Bus addresses 16..31 write message words 0..15. Word i appears at `engBlock[511-32*i -: 32]`. A stored word is the written word XOR 0x5C5C5C5C while the outer pad flag is set. Otherwise it is XOR 0x36363636 while the inner pad flag is set, and unchanged when neither flag is set.
- R4: Both pad flags clear themselves at the done of the block that is running.
- R5: A start command queues the buffer being filled. `engStart` pulses for one cycle when the engine is idle and a buffer is queued. `engInit` is 1 only for the first block after reset and for an outer-pad block. It is 0 for a continuation block.
- R6: With auto-start set, the block is queued once all 16 words are written, and not before.
- R7: A block completely written while a hash runs is queued. It starts after the current done with no start command.
- R8: When an outer-pad block starts, the digest is copied into the other buffer. For SHA-1 the block is: A..E in words 0..4, 0x80000000 in word 5, zeros, and 0x000002A0 in word 15. For MD5/MD4 it is: A..D in words 0..3, 0x00000080 in word 4, zeros, 0x00000280 in word 14 and 0 in word 15. That block runs next with `engInit`=0.
- R9: In step mode, each control write with the step bit set while busy gives exactly one `engRound` cycle. Idle cycles give none. Out of step mode, `engRound` is high on every busy cycle.
- R10: A done pulse sets status bit 0 at address 1, and any write to address 1 clears it. `irq` is that bit AND the interrupt enable.
- R11: Addresses 2..6 read digest words A..E. A is `engDigest[159:128]`. With the byte swap bit set, the byte order of each word is reversed.
- R12: A control write with the reset bit pulses `engAbort` in the same cycle. It clears the control word, status, buffers and queue, so no start or round follows. The next block starts with `engInit`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWr | input | 1 | Bus write strobe |
| busAddr | input | 5 | Bus word address |
| busWdata | input | 32 | Bus write data |
| busRdata | output | 32 | Bus read data (combinational from address) |
| engStart | output | 1 | Start of one block on the engine |
| engInit | output | 1 | Engine loads its initial value before this block |
| engAlgo | output | 2 | Algorithm: 0 SHA-1, 1 MD5, 2 MD4 |
| engBlock | output | 512 | Block presented to the engine |
| engRound | output | 1 | Engine advances one round |
| engDone | input | 1 | Engine finished the block |
| engAbort | output | 1 | Engine abandons its work |
| engDigest | input | 160 | Current digest from the engine |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is the moment when both buffers hold queued blocks while a hash is still in flight. Only then does the no-restart chaining of a second block become visible. The bench reaches it by putting the sequencer in step mode with auto-start. The first block then starts and stays busy without advancing. The bench writes a second full block and checks that nothing starts. It then releases the engine one round per control write and confirms that the second block starts by itself after done. The outer-pad copy is reached in the same way: a start command on a key block, after which the bench checks the engine's own next block for the digest, pad and length words.

// File: rtl/hcs_pkg.sv
package hcs_pkg;
  localparam int DW      = 32;
  localparam int WORDS   = 16;
  localparam int BLK_W   = DW * WORDS;
  localparam int DIG_W   = 160;
  localparam int MD_DIG_W = 128;
  localparam int WIDX_W  = $clog2(WORDS);
  localparam int AW      = WIDX_W + 1;
  localparam int SHA_WORDS = DIG_W / DW;
  localparam int MD_WORDS  = MD_DIG_W / DW;
  localparam int SHA_LEN = BLK_W + DIG_W;
  localparam int MD_LEN  = BLK_W + MD_DIG_W;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_STAT = 1;
  localparam int ADDR_DIG0 = 2;
  localparam int ADDR_MSG0 = WORDS;

  localparam logic [DW-1:0] INNER_PAD = {(DW/8){8'h36}};
  localparam logic [DW-1:0] OUTER_PAD = {(DW/8){8'h5C}};

  // control bit n lives at bus bit DW-1-n
  localparam int B_AUTO  = DW - 1 - 20;
  localparam int B_OUTER = DW - 1 - 21;
  localparam int B_INNER = DW - 1 - 22;
  localparam int B_MD5   = DW - 1 - 24;
  localparam int B_MD4   = DW - 1 - 25;
  localparam int B_RST   = DW - 1 - 26;
  localparam int B_IE    = DW - 1 - 27;
  localparam int B_GO    = DW - 1 - 28;
  localparam int B_SWAP  = DW - 1 - 29;
  localparam int B_STEP  = DW - 1 - 30;

  typedef enum logic [1:0] {ALG_SHA1 = 2'd0, ALG_MD5 = 2'd1, ALG_MD4 = 2'd2} algo_t;
  typedef enum logic [1:0] {PAD_NONE, PAD_INNER, PAD_OUTER} pad_t;

  typedef struct packed {
    logic              clearAll;
    logic              wrEn;
    logic [WIDX_W-1:0] wrIdx;
    logic [DW-1:0]     wrData;
    pad_t              pad;
    logic              fillSel;
    logic              runSel;
    logic              newFill;
    logic              loadDigest;
    algo_t             algo;
  } dpStrobe_t;
endpackage

// File: rtl/hcs_datapath.sv
module hcs_datapath
  import hcs_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic [DIG_W-1:0] digest,
  output logic [BLK_W-1:0] blockOut,
  output logic             fillFull
);
  logic [DW-1:0]    mem  [2][WORDS];
  logic [WORDS-1:0] mask [2];
  logic [DW-1:0]    copyBlk [WORDS];
  logic [DW-1:0]    padMask;

  always_comb begin
    case (stb.pad)
      PAD_INNER: padMask = INNER_PAD;
      PAD_OUTER: padMask = OUTER_PAD;
      default:   padMask = '0;
    endcase
  end

  // digest block with closing pad and total length
  always_comb begin
    for (int i = 0; i < WORDS; i++) begin
      copyBlk[i] = '0;
      if (stb.algo == ALG_SHA1) begin
        if (i < SHA_WORDS)       copyBlk[i] = digest[DIG_W-1-DW*i -: DW];
        else if (i == SHA_WORDS) copyBlk[i] = 32'h8000_0000;
        else if (i == WORDS-1)   copyBlk[i] = DW'(SHA_LEN);
      end else begin
        if (i < MD_WORDS)        copyBlk[i] = digest[DIG_W-1-DW*i -: DW];
        else if (i == MD_WORDS)  copyBlk[i] = 32'h0000_0080;
        else if (i == WORDS-2)   copyBlk[i] = DW'(MD_LEN);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < 2; b++) begin
        mask[b] <= '0;
        for (int i = 0; i < WORDS; i++) mem[b][i] <= '0;
      end
    end else if (stb.clearAll) begin
      for (int b = 0; b < 2; b++) begin
        mask[b] <= '0;
        for (int i = 0; i < WORDS; i++) mem[b][i] <= '0;
      end
    end else begin
      if (stb.loadDigest) begin
        for (int i = 0; i < WORDS; i++) mem[stb.fillSel][i] <= copyBlk[i];
        mask[stb.fillSel] <= '1;
      end else if (stb.wrEn) begin
        mem[stb.fillSel][stb.wrIdx]  <= stb.wrData ^ padMask;
        mask[stb.fillSel][stb.wrIdx] <= 1'b1;
      end
      if (stb.newFill) mask[~stb.fillSel] <= '0;
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_out
    assign blockOut[BLK_W-1-DW*g -: DW] = mem[stb.runSel][g];
  end

  assign fillFull = &mask[stb.fillSel];
endmodule

// File: rtl/hcs_control.sv
module hcs_control
  import hcs_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWr,
  input  logic [AW-1:0]    busAddr,
  input  logic [DW-1:0]    busWdata,
  output logic [DW-1:0]    busRdata,
  input  logic             fillFull,
  input  logic             engDone,
  input  logic [DIG_W-1:0] engDigest,
  output logic             engStart,
  output logic             engInit,
  output algo_t            engAlgo,
  output logic             engRound,
  output logic             engAbort,
  output logic             irq,
  output dpStrobe_t        stb
);
  logic autoGo, outerPad, innerPad, selMd5, selMd4, intEn, swapOut, stepMode;
  logic irqStat, stepPulse, busy, firstBlk, fillIdx, runIdx;
  logic [1:0] ready;

  logic ctrlWr, statWr, msgWr, softRst, goNow;
  logic startNow, copyNow, markNow, doneNow;
  algo_t algo;

  assign ctrlWr  = busWr && int'(busAddr) == ADDR_CTRL;
  assign statWr  = busWr && int'(busAddr) == ADDR_STAT;
  assign msgWr   = busWr && int'(busAddr) >= ADDR_MSG0 && int'(busAddr) < ADDR_MSG0 + WORDS;
  assign softRst = ctrlWr && busWdata[B_RST];
  assign goNow   = ctrlWr && busWdata[B_GO] && !softRst;

  assign algo = selMd5 ? ALG_MD5 : (selMd4 ? ALG_MD4 : ALG_SHA1);

  assign startNow = !busy && ready[runIdx] && !softRst;
  assign copyNow  = startNow && outerPad && !ready[fillIdx];
  assign markNow  = !softRst && !ready[fillIdx] &&
                    (copyNow || goNow || (fillFull && (autoGo || busy)));
  assign doneNow  = busy && engDone && !softRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {autoGo, outerPad, innerPad, selMd5, selMd4, intEn, swapOut, stepMode} <= '0;
      {irqStat, stepPulse, busy, fillIdx, runIdx} <= '0;
      ready    <= '0;
      firstBlk <= 1'b1;
    end else if (softRst) begin
      {autoGo, outerPad, innerPad, selMd5, selMd4, intEn, swapOut, stepMode} <= '0;
      {irqStat, stepPulse, busy, fillIdx, runIdx} <= '0;
      ready    <= '0;
      firstBlk <= 1'b1;
    end else begin
      stepPulse <= ctrlWr && busWdata[B_STEP];
      if (ctrlWr) begin
        autoGo   <= busWdata[B_AUTO];
        outerPad <= busWdata[B_OUTER];
        innerPad <= busWdata[B_INNER];
        selMd5   <= busWdata[B_MD5];
        selMd4   <= busWdata[B_MD4];
        intEn    <= busWdata[B_IE];
        swapOut  <= busWdata[B_SWAP];
        stepMode <= busWdata[B_STEP];
      end
      if (doneNow) begin
        outerPad <= 1'b0;
        innerPad <= 1'b0;
      end
      if (doneNow)     irqStat <= 1'b1;
      else if (statWr) irqStat <= 1'b0;
      if (startNow) begin
        busy     <= 1'b1;
        firstBlk <= 1'b0;
      end
      if (doneNow) begin
        busy          <= 1'b0;
        ready[runIdx] <= 1'b0;
        runIdx        <= ~runIdx;
      end
      if (markNow) begin
        ready[fillIdx] <= 1'b1;
        fillIdx        <= ~fillIdx;
      end
    end
  end

  assign engStart = startNow;
  assign engInit  = firstBlk || outerPad;
  assign engAlgo  = algo;
  assign engRound = busy && (!stepMode || stepPulse);
  assign engAbort = softRst;
  assign irq      = irqStat && intEn;

  always_comb begin
    stb            = '0;
    stb.clearAll   = softRst;
    stb.wrEn       = msgWr && !ready[fillIdx] && !markNow && !softRst;
    stb.wrIdx      = busAddr[WIDX_W-1:0];
    stb.wrData     = busWdata;
    stb.pad        = outerPad ? PAD_OUTER : (innerPad ? PAD_INNER : PAD_NONE);
    stb.fillSel    = fillIdx;
    stb.runSel     = runIdx;
    stb.newFill    = markNow;
    stb.loadDigest = copyNow;
    stb.algo       = algo;
  end

  always_comb begin
    busRdata = '0;
    if (int'(busAddr) == ADDR_CTRL) begin
      busRdata[B_AUTO]  = autoGo;
      busRdata[B_OUTER] = outerPad;
      busRdata[B_INNER] = innerPad;
      busRdata[B_MD5]   = selMd5;
      busRdata[B_MD4]   = selMd4;
      busRdata[B_IE]    = intEn;
      busRdata[B_SWAP]  = swapOut;
      busRdata[B_STEP]  = stepMode;
    end else if (int'(busAddr) == ADDR_STAT) begin
      busRdata[0] = irqStat;
    end else begin
      for (int k = 0; k < SHA_WORDS; k++) begin
        if (int'(busAddr) == ADDR_DIG0 + k) begin
          busRdata = engDigest[DIG_W-1-DW*k -: DW];
          if (swapOut) busRdata = {<<8{busRdata}};
        end
      end
    end
  end
endmodule

// File: rtl/hash_ctrl_seq.sv
module hash_ctrl_seq
  import hcs_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWr,
  input  logic [AW-1:0]    busAddr,
  input  logic [DW-1:0]    busWdata,
  output logic [DW-1:0]    busRdata,
  output logic             engStart,
  output logic             engInit,
  output logic [1:0]       engAlgo,
  output logic [BLK_W-1:0] engBlock,
  output logic             engRound,
  input  logic             engDone,
  output logic             engAbort,
  input  logic [DIG_W-1:0] engDigest,
  output logic             irq
);
  dpStrobe_t stb;
  logic      fillFull;
  algo_t     algo;

  hcs_control u_control (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .fillFull(fillFull), .engDone(engDone), .engDigest(engDigest),
    .engStart(engStart), .engInit(engInit), .engAlgo(algo), .engRound(engRound),
    .engAbort(engAbort), .irq(irq), .stb(stb)
  );

  hcs_datapath u_datapath (
    .clk(clk), .rstN(rstN), .stb(stb), .digest(engDigest),
    .blockOut(engBlock), .fillFull(fillFull)
  );

  assign engAlgo = algo;
endmodule

// File: rtl/hcs_checker.sv
module hcs_checker
  import hcs_pkg::*;
(
  input logic          clk,
  input logic          rstN,
  input logic          busWr,
  input logic [AW-1:0] busAddr,
  input logic          engStart,
  input logic          engRound,
  input logic          engAbort,
  input logic          engDone,
  input logic          irq
);
  a_r5_single_start: assert property (@(posedge clk) disable iff (!rstN)
    engStart |=> !engStart);

  a_r9_no_round_at_start: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> !engRound);

  a_r12_abort_quiet: assert property (@(posedge clk) disable iff (!rstN)
    engAbort |=> (!engStart && !engRound));

  a_r12_abort_drops_irq: assert property (@(posedge clk) disable iff (!rstN)
    engAbort |=> !irq);

  a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(engDone) || $past(busWr && busAddr == '0)));
endmodule

bind hash_ctrl_seq hcs_checker u_chk (.*);

// File: tb/test_hash_ctrl_seq.sv
module test_hash_ctrl_seq;
  localparam int HALF = 2;
  localparam int RNDS = 4;
  localparam logic [159:0] DIG = 160'h01234567_89ABCDEF_FEDCBA98_76543210_0F1E2D3C;
  localparam logic [31:0] C_AUTO = 32'h800, C_OUTER = 32'h400, C_INNER = 32'h200,
                          C_MD5 = 32'h80, C_MD4 = 32'h40, C_RST = 32'h20, C_IE = 32'h10,
                          C_GO = 32'h8, C_SWAP = 32'h4, C_STEP = 32'h2;

  typedef struct packed { logic [31:0] wr; logic [31:0] exp; } vec_t;
  localparam vec_t VECS [6] = '{
    '{32'hFFFF_FFD7, 32'h0000_0ED6},
    '{32'h0000_0800, 32'h0000_0800},
    '{32'hFFFF_F000, 32'h0000_0000},
    '{32'h0000_0101, 32'h0000_0000},
    '{32'h0000_00C4, 32'h0000_00C4},
    '{32'hFFFF_FFFF, 32'h0000_0000}
  };

  logic clk = 0, rstN = 0, busWr = 0;
  logic [4:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic engStart, engInit, engRound, engAbort, irq;
  logic engDone = 0;
  logic [1:0] engAlgo;
  logic [511:0] engBlock;
  logic [159:0] engDigest;

  int nVec = 0, nBad = 0;
  int nStarts = 0, nDone = 0, nRounds = 0, nAbort = 0, rc = 0;
  logic [511:0] capBlock = '0;
  logic capInit = 0;
  logic [1:0] capAlgo = '0;

  assign engDigest = DIG;
  always #HALF clk = ~clk;

  hash_ctrl_seq i_hash_ctrl_seq (.*);

  // behavioural round engine
  always @(posedge clk) begin
    engDone <= 1'b0;
    if (engAbort) nAbort <= nAbort + 1;
    if (engRound) nRounds <= nRounds + 1;
    if (engStart) begin
      nStarts <= nStarts + 1;
      capBlock <= engBlock;
      capInit <= engInit;
      capAlgo <= engAlgo;
    end
    if (engAbort || engStart) rc <= 0;
    else if (engRound && !engDone) begin
      if (rc == RNDS - 1) begin
        engDone <= 1'b1;
        nDone <= nDone + 1;
        rc <= 0;
      end else rc <= rc + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic readReg(input logic [4:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic writeBlock(input logic [31:0] base);
    for (int i = 0; i < 16; i++) busWrite(5'(16 + i), base + 32'(i));
  endtask

  task automatic waitStarts(input int n);
    int t = 0;
    while (nStarts < n && t < 500) begin @(negedge clk); t++; end
  endtask

  task automatic waitDone(input int n);
    int t = 0;
    while (nDone < n && t < 500) begin @(negedge clk); t++; end
    @(negedge clk);
  endtask

  function automatic logic [31:0] blkWord(input int i);
    return capBlock[511-32*i -: 32];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int ns, nd, nr;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    readReg(0, rd); chk("R1 reset ctrl", rd, 0);
    readReg(1, rd); chk("R10 reset status", rd, 0);
    chk("R10 reset irq", 32'(irq), 0);
    chk("R5 reset no start", 32'(nStarts), 0);

    // control word vectors
    foreach (VECS[v]) begin
      busWrite(0, VECS[v].wr);
      readReg(0, rd);
      chk($sformatf("R1 ctrl vector %0d", v), rd, VECS[v].exp);
    end

    // inner pad, SHA-1, first block
    busWrite(0, C_INNER | C_IE);
    writeBlock(32'hA500_0000);
    ns = nStarts; nd = nDone;
    busWrite(0, C_INNER | C_IE | C_GO);
    waitStarts(ns + 1);
    chk("R5 start after go", 32'(nStarts), 32'(ns + 1));
    chk("R5 first block init", 32'(capInit), 1);
    chk("R2 sha1 select", 32'(capAlgo), 0);
    chk("R3 inner pad w0", blkWord(0), 32'hA500_0000 ^ 32'h3636_3636);
    chk("R3 inner pad w15", blkWord(15), 32'hA500_000F ^ 32'h3636_3636);
    waitDone(nd + 1);
    chk("R10 irq after done", 32'(irq), 1);
    readReg(1, rd); chk("R10 status set", rd, 1);
    readReg(0, rd); chk("R4 inner pad cleared", rd, C_IE);
    busWrite(1, 0);
    chk("R10 irq cleared", 32'(irq), 0);

    // auto-start, MD4, continuation
    busWrite(0, C_AUTO | C_MD4);
    ns = nStarts; nd = nDone;
    for (int i = 0; i < 15; i++) busWrite(5'(16 + i), 32'h7700_0000 + 32'(i));
    repeat (4) @(negedge clk);
    chk("R6 no start at 15 words", 32'(nStarts), 32'(ns));
    busWrite(31, 32'h7700_000F);
    waitStarts(ns + 1);
    chk("R6 start at 16 words", 32'(nStarts), 32'(ns + 1));
    chk("R5 continuation init", 32'(capInit), 0);
    chk("R2 md4 select", 32'(capAlgo), 2);
    chk("R3 plain word 3", blkWord(3), 32'h7700_0003);
    waitDone(nd + 1);

    // both algorithm bits: MD5 wins
    ns = nStarts; nd = nDone;
    busWrite(0, C_MD5 | C_MD4 | C_GO);
    waitStarts(ns + 1);
    chk("R2 md5 priority", 32'(capAlgo), 1);
    waitDone(nd + 1);

    // double buffer in step mode
    busWrite(0, C_RST);
    busWrite(0, C_AUTO | C_STEP);
    ns = nStarts; nd = nDone;
    writeBlock(32'hB000_0000);
    waitStarts(ns + 1);
    writeBlock(32'hC000_0000);
    repeat (10) @(negedge clk);
    chk("R7 second block held while busy", 32'(nStarts), 32'(ns + 1));
    nr = nRounds;
    chk("R9 no rounds while idle in step", 32'(nRounds - nr), 0);
    for (int s = 0; s < 3; s++) begin
      busWrite(0, C_AUTO | C_STEP);
      repeat (2) @(negedge clk);
    end
    chk("R9 three steps three rounds", 32'(nRounds - nr), 3);
    chk("R9 not done after three steps", 32'(nDone), 32'(nd));
    busWrite(0, C_AUTO | C_STEP);
    waitStarts(ns + 2);
    chk("R7 chained start", 32'(nStarts), 32'(ns + 2));
    chk("R7 chained block w0", blkWord(0), 32'hC000_0000);
    chk("R7 chained init", 32'(capInit), 0);

    // outer pad with digest copy, SHA-1
    busWrite(0, C_RST);
    busWrite(0, C_OUTER | C_IE);
    writeBlock(32'hD000_0000);
    ns = nStarts; nd = nDone;
    busWrite(0, C_OUTER | C_IE | C_GO);
    waitStarts(ns + 1);
    chk("R5 outer block init", 32'(capInit), 1);
    chk("R3 outer pad w2", blkWord(2), 32'hD000_0002 ^ 32'h5C5C_5C5C);
    waitStarts(ns + 2);
    chk("R8 sha copy w0", blkWord(0), DIG[159:128]);
    chk("R8 sha copy w4", blkWord(4), DIG[31:0]);
    chk("R8 sha pad w5", blkWord(5), 32'h8000_0000);
    chk("R8 sha zero w14", blkWord(14), 0);
    chk("R8 sha length w15", blkWord(15), 32'h0000_02A0);
    chk("R8 copy block init", 32'(capInit), 0);
    readReg(0, rd); chk("R4 outer pad cleared", rd, C_IE);
    waitDone(nd + 2);

    // outer pad with digest copy, MD5
    busWrite(0, C_RST);
    ns = nStarts; nd = nDone;
    busWrite(0, C_OUTER | C_MD5 | C_GO);
    waitStarts(ns + 2);
    chk("R8 md copy w3", blkWord(3), DIG[63:32]);
    chk("R8 md pad w4", blkWord(4), 32'h0000_0080);
    chk("R8 md zero w5", blkWord(5), 0);
    chk("R8 md length w14", blkWord(14), 32'h0000_0280);
    chk("R8 md length w15", blkWord(15), 0);
    waitDone(nd + 2);

    // interrupt gating and digest readout
    readReg(1, rd); chk("R10 status with enable off", rd, 1);
    chk("R10 irq gated off", 32'(irq), 0);
    busWrite(0, C_IE);
    chk("R10 irq with enable", 32'(irq), 1);
    readReg(2, rd); chk("R11 digest A plain", rd, 32'h0123_4567);
    readReg(6, rd); chk("R11 digest E plain", rd, 32'h0F1E_2D3C);
    busWrite(0, C_SWAP);
    readReg(2, rd); chk("R11 digest A swapped", rd, 32'h6745_2301);
    readReg(3, rd); chk("R11 digest B swapped", rd, 32'hEFCD_AB89);
    readReg(6, rd); chk("R11 digest E swapped", rd, 32'h3C2D_1E0F);

    // soft reset during a hash
    ns = nStarts;
    busWrite(0, C_STEP | C_GO | C_IE);
    waitStarts(ns + 1);
    nd = nAbort;
    busWrite(0, C_RST);
    chk("R12 abort pulse", 32'(nAbort), 32'(nd + 1));
    readReg(0, rd); chk("R12 ctrl cleared", rd, 0);
    readReg(1, rd); chk("R12 status cleared", rd, 0);
    chk("R12 irq low", 32'(irq), 0);
    nr = nRounds;
    repeat (20) @(negedge clk);
    chk("R12 no start after abort", 32'(nStarts), 32'(ns + 1));
    chk("R12 no rounds after abort", 32'(nRounds - nr), 0);
    busWrite(0, C_GO);
    waitStarts(ns + 2);
    chk("R12 fresh chain init", 32'(capInit), 1);
    repeat (10) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule